// File: doc/BRIEF.md
# DTMF Steering Guard-Time Controller

This block does in logic what a resistor-capacitor steering network does for a dual-tone receiver. An upstream tone-pair detector supplies an early-steer level and a 4-bit key code. The block decides when a tone has lasted long enough to count as a digit, and when a silence has lasted long enough to end that digit. Both decisions use programmable guard times counted in ticks of a tick-enable strobe. Because the two guard times are separate, the accept and release thresholds can differ, which gives the block hysteresis.

When a tone is accepted, its code is written into an output latch. One cycle later the delayed-steering flag rises. The flag falls only after the tone-absent guard has run out. A gap in early-steer that is shorter than that guard counts as a dropout and is bridged. The data outputs hold the last accepted code. They are modelled as a data vector plus a separate drive-enable that mirrors an output-enable input. That input should be tied high when unused, as a pull-up would do.

Top module: `dtmf_steer_guard`

## Requirements
- R1: A synchronous reset `rst` puts the block in idle. It clears the code latch to 0 and drives `steer_dly` and `guard_out` low.
- R2: `est_in` is passed through a two-flop synchronizer. With a tick on every cycle and a tone-present guard G≥1, a tone held long enough is accepted. Counting from the clock edge after `est_in` rises, `steer_dly` goes high on edge G+4. A guard of 0 behaves like a guard of 1.
- R3: A high pulse on `est_in` that is shorter than the tone-present guard is rejected. The latch does not change and `steer_dly` stays low.
- R4: On acceptance, `data_q` takes the new code and `guard_out` rises on the same edge. `steer_dly` rises one cycle later, with `data_q` unchanged between those two edges.
- R5: After an accepted tone ends, `est_in` must stay low for the tone-absent guard Ga. With a tick on every cycle, `guard_out` falls on edge Ga+3 and `steer_dly` falls on edge Ga+4, both counted from the edge after the fall of `est_in`.
- R6: A low gap on `est_in` shorter than the tone-absent guard is a dropout. `steer_dly` stays high throughout and the latch is not reloaded, even if `code_in` changes during the gap.
- R7: The two guard times are independent and either may be the longer. A new tone is accepted only after the previous digit has been released. `steer_dly` always equals `guard_out` delayed by one cycle.
- R8: `data_drive` equals `out_en` at all times. `data_q` holds the last accepted code, with bit 0 as the LSB.
- R9: Key codes follow this map: digits 1 to 9 are 1 to 9, digit 0 is 10, `*` is 11, `#` is 12, A, B and C are 13, 14 and 15, and D is 0.
- R10: The guard counters advance only on cycles where `tick` is high. A slower tick stretches the acceptance latency in proportion to the tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Guard counter advance strobe |
| est_in | input | 1 | Early-steer level from tone detector (asynchronous) |
| code_in | input | 4 | Key code from tone detector |
| present_guard | input | CNT_W | Tone-present guard time in ticks |
| absent_guard | input | CNT_W | Tone-absent guard time in ticks |
| out_en | input | 1 | Output enable for the data bits |
| data_q | output | 4 | Code of the last accepted tone pair |
| data_drive | output | 1 | Drive enable for data_q (low = high impedance) |
| steer_dly | output | 1 | Delayed steering flag |
| guard_out | output | 1 | Internal steering state, for observability |

## Verification
The bench measures acceptance and release latency to the exact cycle. A counter that is off by one, or a synchronizer with the wrong depth, therefore shows up as a shifted edge. Pulses two cycles shorter than the present guard must produce no digit; a design that compares with the wrong sense would accept them. Gaps two cycles shorter than the absent guard must not lower the flag, and `code_in` is changed during the gap to catch a design that relatches on a dropout. Guards of zero, asymmetric guards, a divided tick, a reset in the middle of a digit and a disabled output each check a path that a simple design would get wrong.

// File: rtl/dtmf_guard_pkg.sv
package dtmf_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PRESENT = 2'd1,
    ST_HOLD    = 2'd2,
    ST_ABSENT  = 2'd3
  } steer_st_e;

  // Guard completes this cycle: zero limit completes at once,
  // otherwise the tick that brings the count up to the limit.
  function automatic logic guard_done(input logic [31:0] cnt,
                                      input logic        tick,
                                      input logic [31:0] limit);
    return (limit == 32'd0) || (tick && ((cnt + 32'd1) >= limit));
  endfunction

  function automatic logic holds_digit(input steer_st_e st);
    return (st == ST_HOLD) || (st == ST_ABSENT);
  endfunction

endpackage

// File: rtl/dtmf_est_sync.sv
module dtmf_est_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer
  import dtmf_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
  end

  assign done = guard_done(32'(cnt), tick, 32'(limit));
endmodule

// File: rtl/dtmf_code_latch.sv
module dtmf_code_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dtmf_steer_guard.sv
module dtmf_steer_guard
  import dtmf_guard_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              est_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CNT_W-1:0]  present_guard,
  input  logic [CNT_W-1:0]  absent_guard,
  input  logic              out_en,
  output logic [CODE_W-1:0] data_q,
  output logic              data_drive,
  output logic              steer_dly,
  output logic              guard_out
);
  steer_st_e        st, st_nxt;
  logic             est_s;
  logic             tmr_done;
  logic             tmr_clr;
  logic [CNT_W-1:0] tmr_limit;

  // named internal events, used by the checker
  logic accept_evt, reject_evt, dropout_evt, release_evt;

  dtmf_est_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(est_in), .q(est_s)
  );

  assign tmr_limit = (st == ST_ABSENT) ? absent_guard : present_guard;
  assign tmr_clr   = (st_nxt != st);

  dtmf_guard_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick),
    .limit(tmr_limit), .done(tmr_done)
  );

  assign accept_evt  = (st == ST_PRESENT) &&  est_s && tmr_done;
  assign reject_evt  = (st == ST_PRESENT) && !est_s;
  assign dropout_evt = (st == ST_ABSENT)  &&  est_s;
  assign release_evt = (st == ST_ABSENT)  && !est_s && tmr_done;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:    if (est_s)       st_nxt = ST_PRESENT;
      ST_PRESENT: if (reject_evt)  st_nxt = ST_IDLE;
                  else if (accept_evt) st_nxt = ST_HOLD;
      ST_HOLD:    if (!est_s)      st_nxt = ST_ABSENT;
      ST_ABSENT:  if (dropout_evt) st_nxt = ST_HOLD;
                  else if (release_evt) st_nxt = ST_IDLE;
      default:    st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  dtmf_code_latch #(.W(CODE_W)) u_latch (
    .clk(clk), .rst(rst), .load(accept_evt), .d(code_in), .q(data_q)
  );

  assign guard_out = holds_digit(st);

  always_ff @(posedge clk) begin
    if (rst) steer_dly <= 1'b0;
    else     steer_dly <= guard_out;
  end

  assign data_drive = out_en;
endmodule

// File: rtl/dtmf_steer_guard_chk.sv
module dtmf_steer_guard_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              out_en,
  input logic [CODE_W-1:0] data_q,
  input logic              data_drive,
  input logic              steer_dly,
  input logic              guard_out,
  input logic              accept_evt,
  input logic              dropout_evt,
  input logic              release_evt
);
  a_r4_latch_before_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_dly) |-> ($past(guard_out) && $stable(data_q)));

  a_r7_flag_tracks_guard_hi: assert property (@(posedge clk) disable iff (rst)
    guard_out |=> steer_dly);

  a_r7_flag_tracks_guard_lo: assert property (@(posedge clk) disable iff (rst)
    !guard_out |=> !steer_dly);

  a_r7_no_accept_while_held: assert property (@(posedge clk) disable iff (rst)
    accept_evt |-> !guard_out);

  a_r6_dropout_keeps_digit: assert property (@(posedge clk) disable iff (rst)
    dropout_evt |=> (guard_out && $stable(data_q)));

  a_r6_latch_only_on_accept: assert property (@(posedge clk) disable iff (rst)
    !accept_evt |=> $stable(data_q));

  a_r5_release_drops_guard: assert property (@(posedge clk) disable iff (rst)
    release_evt |=> !guard_out);

  a_r8_drive_follows_enable: assert property (@(posedge clk) disable iff (rst)
    data_drive == out_en);
endmodule

bind dtmf_steer_guard dtmf_steer_guard_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .out_en(out_en), .data_q(data_q),
  .data_drive(data_drive), .steer_dly(steer_dly), .guard_out(guard_out),
  .accept_evt(accept_evt), .dropout_evt(dropout_evt),
  .release_evt(release_evt)
);

// File: tb/dtmf_steer_guard_tb_top.sv
module dtmf_steer_guard_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b1;
  logic             est_in = 1'b0;
  logic [3:0]       code_in = 4'd0;
  logic [CNT_W-1:0] present_guard = 16'd5;
  logic [CNT_W-1:0] absent_guard = 16'd6;
  logic             out_en = 1'b1;
  logic [3:0]       data_q;
  logic             data_drive, steer_dly, guard_out;

  int  cyc = 0;
  int  tick_div = 1;
  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  typedef struct {
    logic [3:0] code;
    int         lat_lo;
    int         lat_hi;
  } exp_t;
  exp_t exp_q[$];
  int   rise_cyc = 0;

  dtmf_steer_guard #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .est_in(est_in), .code_in(code_in),
    .present_guard(present_guard), .absent_guard(absent_guard),
    .out_en(out_en), .data_q(data_q), .data_drive(data_drive),
    .steer_dly(steer_dly), .guard_out(guard_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R9 key map, restated here
  function automatic logic [3:0] key_code(input byte k);
    case (k)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      "D": return 4'd0;
      default: return 4'(k - "0");
    endcase
  endfunction

  // drive a tone; optionally push the expected digit
  task automatic send_tone(input byte k, input int hold, input bit acc,
                           input int lo, input int hi);
    exp_t e;
    @(negedge clk);
    code_in  = key_code(k);
    est_in   = 1'b1;
    rise_cyc = cyc;
    if (acc) begin
      e.code = key_code(k); e.lat_lo = lo; e.lat_hi = hi;
      exp_q.push_back(e);
    end
    repeat (hold) @(negedge clk);
  endtask

  // end tone, measure release edges (tick every cycle)
  task automatic end_tone(input int ga);
    int n = 0;
    int g_fall = -1;
    est_in = 1'b0;
    while (steer_dly && n < 200) begin
      @(negedge clk);
      n++;
      if (!guard_out && g_fall < 0) g_fall = n;
    end
    chk(n == ga + 4, "R5 steer_dly fall latency", n, ga + 4);
    chk(g_fall == ga + 3, "R7 guard_out falls one cycle before steer_dly", g_fall, ga + 3);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor: on each rise of steer_dly pop one expected digit
  initial begin
    logic prev_dly = 1'b0, prev_guard = 1'b0;
    logic [3:0] prev_data = 4'd0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && steer_dly && !prev_dly) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected digit accepted", int'(data_q), -1);
        end else begin
          e = exp_q.pop_front();
          chk(data_q == e.code, "R8 latched code", int'(data_q), int'(e.code));
          chk((cyc - rise_cyc) >= e.lat_lo && (cyc - rise_cyc) <= e.lat_hi,
              "R2 acceptance latency", cyc - rise_cyc, e.lat_lo);
          chk(prev_guard && prev_data == data_q,
              "R4 latch loaded before flag", int'(prev_data), int'(data_q));
        end
      end
      prev_dly = steer_dly; prev_guard = guard_out; prev_data = data_q;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(data_q == 4'd0 && !steer_dly && !guard_out, "R1 reset state",
        int'({steer_dly, guard_out, data_q}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 basic accept, G=5, Ga=6
    send_tone("5", 20, 1'b1, 9, 9);
    chk(data_drive == 1'b1, "R8 drive follows enable", int'(data_drive), 1);
    end_tone(6);

    // R9 codes, R7 asymmetric guards (present longer than absent)
    present_guard = 16'd8; absent_guard = 16'd2;
    send_tone("#", 20, 1'b1, 12, 12);
    end_tone(2);
    send_tone("D", 20, 1'b1, 12, 12);
    chk(data_q == 4'd0, "R9 key D encodes as 0", int'(data_q), 0);
    end_tone(2);
    present_guard = 16'd3; absent_guard = 16'd9;
    send_tone("*", 15, 1'b1, 7, 7);
    end_tone(9);
    send_tone("C", 15, 1'b1, 7, 7);
    end_tone(9);

    // R3 short pulse rejected
    present_guard = 16'd6; absent_guard = 16'd5;
    send_tone("7", 4, 1'b0, 0, 0);
    est_in = 1'b0;
    repeat (12) @(negedge clk);
    chk(!steer_dly && data_q == 4'd15, "R3 short pulse leaves latch and flag",
        int'(data_q), 15);

    // R6 dropout bridged, code change during gap ignored
    send_tone("0", 14, 1'b1, 10, 10);
    est_in = 1'b0;
    code_in = 4'd3;
    n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!steer_dly) n++;
    end
    est_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!steer_dly) n++;
    end
    chk(n == 0, "R6 flag stays high over dropout", n, 0);
    chk(data_q == 4'd10, "R6 no relatch on dropout", int'(data_q), 10);
    end_tone(5);

    // R7 new digit right after release
    send_tone("8", 16, 1'b1, 10, 10);
    end_tone(5);

    // R2 zero guard behaves as one
    present_guard = 16'd0; absent_guard = 16'd1;
    send_tone("1", 10, 1'b1, 5, 5);
    end_tone(1);

    // R10 slow tick stretches latency
    tick_div = 4; present_guard = 16'd3;
    send_tone("A", 30, 1'b1, 4 * 2 + 4, 4 * 3 + 4);
    tick_div = 1;
    end_tone(1);

    // R8 output enable low
    @(negedge clk);
    out_en = 1'b0;
    @(negedge clk);
    chk(data_drive == 1'b0, "R8 drive off when enable low", int'(data_drive), 0);
    chk(data_q == 4'd13, "R8 data holds last code", int'(data_q), 13);
    out_en = 1'b1;

    // R1 reset in the middle of a digit
    send_tone("9", 12, 1'b1, 7, 7);
    est_in = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(data_q == 4'd0 && !steer_dly && !guard_out, "R1 mid-digit reset clears",
        int'({steer_dly, guard_out, data_q}), 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected digits seen", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule